// File: doc/BRIEF.md
# Asymmetric Gate Command Pulse Filter

This block cleans up the six active-low switch commands of a three-leg power bridge before they reach the interlock and dead-time logic. Each leg has a low-side command and a high-side command. Every command is first brought into the clock domain by a two-stage synchroniser. It then passes through a filter channel of its own, built around a saturating counter. A command level of 0 means "switch on" and 1 means "switch off", on the inputs and on the filtered outputs alike.

Low-side channels are symmetric. A new level reaches the output only after it has been held for `LS_FILT_CYC` clock cycles, and this holds for both directions. High-side channels are asymmetric. A turn-on must be held for `HS_ON_CYC` cycles. A turn-off is judged by the width of the off-pulse. Off-pulses shorter than `HS_OFF_SHORT_CYC` cycles are dropped. Off-pulses of at least `HS_OFF_LONG_CYC` cycles go through unchanged. Off-pulses whose width falls between these two limits produce a turn-off that is stretched to the long limit, so that the switch never sees an off-time of uncertain length. All time constants are parameters counted in clock cycles. The defaults assume a 200 MHz clock and give about 270 ns, 220 ns and 400 ns. The system should still drive the block with command pulses of 1 µs or wider. Narrower pulses are only handled in the sense defined below.

Top module: `gate_input_filter`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, and on the first cycles after it rises, all six filtered outputs are 1 (off).
- R2: A low-side output follows its raw command `LS_FILT_CYC + 2` clock cycles after the command changes, as long as the new level is held throughout. This applies to the 1-to-0 (on) edge and to the 0-to-1 (off) edge alike.
- R3: A low-side pulse of either polarity that lasts fewer than `LS_FILT_CYC` cycles leaves the low-side output unchanged. A pulse of exactly `LS_FILT_CYC` cycles is passed.
- R4: While a high-side output is 1, a 0 on its command turns the output to 0 `HS_ON_CYC + 2` cycles after the command fell, provided the 0 is held. A 0 held for fewer than `HS_ON_CYC` cycles is ignored.
- R5: While a high-side output is 0, an off-pulse (command at 1) lasting fewer than `HS_OFF_SHORT_CYC` cycles is ignored, and the output stays 0.
- R6: While a high-side output is 0, an off-pulse of W ≥ `HS_OFF_LONG_CYC` cycles sets the output to 1 `HS_OFF_SHORT_CYC + 2` cycles after the command rose. The output returns to 0 `W + HS_ON_CYC + 2` cycles after the command rose.
- R7: While a high-side output is 0, an off-pulse of W cycles, with `HS_OFF_SHORT_CYC` ≤ W < `HS_OFF_LONG_CYC`, sets the output to 1 `HS_OFF_SHORT_CYC + 2` cycles after the command rose. The output returns to 0 `HS_OFF_LONG_CYC + HS_ON_CYC + 2` cycles after the command rose. Once a high-side output has turned off, it therefore stays off for at least `HS_OFF_LONG_CYC - HS_OFF_SHORT_CYC + HS_ON_CYC` cycles.
- R8: Channels are independent. Activity on one command never changes the output of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock; all time constants count its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| ls_cmd_n | input | N_LEGS | Raw low-side commands, asynchronous, 0 = on |
| hs_cmd_n | input | N_LEGS | Raw high-side commands, asynchronous, 0 = on |
| ls_out_n | output | N_LEGS | Filtered low-side commands, 0 = on |
| hs_out_n | output | N_LEGS | Filtered high-side commands, 0 = on |

## Verification
The assertions assume that the parameters are ordered so that `HS_OFF_LONG_CYC` > `HS_OFF_SHORT_CYC` ≥ 1 and that every filter time is at least 1. They also assume that the commands are only ever observed through the synchroniser, so that each check measures how long the synchronised level has been stable. The stimulus changes the raw commands half a cycle away from the sampling edge and moves one channel at a time. Every pulse is started only after the previous filtered transition, including any stretched off-time, has completed, so each expected edge falls on one exactly predictable cycle.

// File: rtl/gif_pkg.sv
// Shared definitions for the gate command pulse filter.
// Assumes: nothing beyond the standard language.
package gif_pkg;

    // State of one high-side filter channel.
    typedef enum logic [1:0] {
        HS_OFF  = 2'd0,   // output off, watching for a held turn-on
        HS_ON   = 2'd1,   // output on, timing any off-pulse
        HS_HOLD = 2'd2    // output off, minimum off-time still running
    } hs_state_e;

    // Larger of two integers, for sizing counters at elaboration.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gif_sync.sv
// Two-stage synchroniser for a bus of independent active-low commands.
// Assumes: every bit is an unrelated asynchronous level, and reset
// leaves each stage at the inactive level (1).
module gif_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;

    // Two flops in series: the first may go metastable, the second resolves it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            q_sync <= '1;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/gif_sym_filter.sv
// Symmetric level filter for one command. The output takes a new input
// level only after that level has been sampled on FILT_CYC consecutive
// clocks, and it treats both directions the same way.
// Assumes: FILT_CYC >= 1 and an input that is already synchronous.
module gif_sym_filter #(
    parameter int FILT_CYC = 54
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    output logic cmd_f
);

    localparam int              CW   = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0]   LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks of disagreement; adopt the input once the count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_f <= 1'b1;
            cnt_q <= '0;
        end else if (cmd_s == cmd_f) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cmd_f <= cmd_s;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/gif_hs_filter.sv
// Asymmetric filter for one high-side command.
// A turn-on must be held for ON_CYC clocks. An off-pulse shorter than
// OFF_SHORT_CYC clocks is dropped. Any longer off-pulse turns the output
// off, and the output then stays off until OFF_LONG_CYC clocks have passed
// since the pulse began. After that, the normal turn-on filter applies.
// Assumes: ON_CYC >= 1, OFF_SHORT_CYC >= 1, OFF_LONG_CYC > OFF_SHORT_CYC,
// and an input that is already synchronous.
module gif_hs_filter
    import gif_pkg::*;
#(
    parameter int ON_CYC        = 54,
    parameter int OFF_SHORT_CYC = 44,
    parameter int OFF_LONG_CYC  = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    output logic cmd_f
);

    localparam int            CW         = $clog2(max2(ON_CYC, OFF_LONG_CYC) + 1);
    localparam logic [CW-1:0] ON_LAST    = CW'(ON_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(OFF_SHORT_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(OFF_LONG_CYC - OFF_SHORT_CYC - 1);

    hs_state_e     state_q;
    logic [CW-1:0] cnt_q;

    // Single counter shared by the three phases: on filter, off-pulse timer, hold timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_OFF;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                HS_OFF: begin
                    if (cmd_s) begin
                        cnt_q <= '0;
                    end else if (cnt_q == ON_LAST) begin
                        state_q <= HS_ON;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                HS_ON: begin
                    if (!cmd_s) begin
                        cnt_q <= '0;
                    end else if (cnt_q == SHORT_LAST) begin
                        state_q <= HS_HOLD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                HS_HOLD: begin
                    if (cnt_q == HOLD_LAST) begin
                        state_q <= HS_OFF;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= HS_OFF;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // The output is on only in the ON state; the state is a register, so there are no glitches.
    assign cmd_f = (state_q != HS_ON);

endmodule

// File: rtl/gate_input_filter.sv
// Top of the gate command pulse filter: synchronises the raw active-low
// commands of N_LEGS bridge legs and filters each one. Low-side channels
// use a symmetric filter and high-side channels an asymmetric one.
// Assumes: raw commands are asynchronous levels. All time constants are
// counted in clk cycles, with HS_OFF_LONG_CYC > HS_OFF_SHORT_CYC >= 1.
module gate_input_filter #(
    parameter int N_LEGS           = 3,
    parameter int LS_FILT_CYC      = 54,
    parameter int HS_ON_CYC        = 54,
    parameter int HS_OFF_SHORT_CYC = 44,
    parameter int HS_OFF_LONG_CYC  = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LEGS-1:0] ls_cmd_n,
    input  logic [N_LEGS-1:0] hs_cmd_n,
    output logic [N_LEGS-1:0] ls_out_n,
    output logic [N_LEGS-1:0] hs_out_n
);

    localparam int NCH = 2 * N_LEGS;

    logic [NCH-1:0]    raw_all;
    logic [NCH-1:0]    sync_all;
    logic [N_LEGS-1:0] ls_sync;
    logic [N_LEGS-1:0] hs_sync;

    // Bring all commands into the clock domain through one synchroniser bank.
    assign raw_all = {hs_cmd_n, ls_cmd_n};

    gif_sync #(.WIDTH(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_all),
        .q_sync  (sync_all)
    );

    assign ls_sync = sync_all[N_LEGS-1:0];
    assign hs_sync = sync_all[NCH-1:N_LEGS];

    // One symmetric filter per low-side command and one asymmetric filter per high-side command.
    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        gif_sym_filter #(.FILT_CYC(LS_FILT_CYC)) u_ls (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd_s (ls_sync[g]),
            .cmd_f (ls_out_n[g])
        );

        gif_hs_filter #(
            .ON_CYC        (HS_ON_CYC),
            .OFF_SHORT_CYC (HS_OFF_SHORT_CYC),
            .OFF_LONG_CYC  (HS_OFF_LONG_CYC)
        ) u_hs (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd_s (hs_sync[g]),
            .cmd_f (hs_out_n[g])
        );
    end

endmodule

// File: rtl/gate_input_filter_chk.sv
// Property checker for gate_input_filter, bound to every instance.
// It measures how long each synchronised command has been stable and how
// long each high-side output has been off, and relates output changes to
// those measurements.
// Assumes: the same parameter values as the bound instance.
module gate_input_filter_chk
    import gif_pkg::*;
#(
    parameter int N_LEGS           = 3,
    parameter int LS_FILT_CYC      = 54,
    parameter int HS_ON_CYC        = 54,
    parameter int HS_OFF_SHORT_CYC = 44,
    parameter int HS_OFF_LONG_CYC  = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_LEGS-1:0] ls_sync,
    input logic [N_LEGS-1:0] hs_sync,
    input logic [N_LEGS-1:0] ls_out_n,
    input logic [N_LEGS-1:0] hs_out_n
);

    localparam int OFF_MIN = HS_OFF_LONG_CYC - HS_OFF_SHORT_CYC + HS_ON_CYC;
    localparam int SAT     = max2(max2(LS_FILT_CYC, HS_ON_CYC), max2(HS_OFF_SHORT_CYC, OFF_MIN));
    localparam int RW      = $clog2(SAT + 1);
    localparam logic [RW-1:0] SAT_V   = RW'(SAT);
    localparam logic [RW-1:0] LS_MIN  = RW'(LS_FILT_CYC);
    localparam logic [RW-1:0] ON_MIN  = RW'(HS_ON_CYC);
    localparam logic [RW-1:0] SH_MIN  = RW'(HS_OFF_SHORT_CYC);
    localparam logic [RW-1:0] OFF_MINV = RW'(OFF_MIN);

    logic rst_seen_q;

    // Remember that the previous edge was a reset edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Outputs must be off right after any reset edge.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            AST_RESET_OFF: assert ((&ls_out_n) && (&hs_out_n)) else $error("outputs not off after reset"); // R1
        end
    end

    for (genvar i = 0; i < N_LEGS; i++) begin : g_chk
        logic [RW-1:0] ls_run_q;
        logic          ls_last_q;
        logic [RW-1:0] hs_run_q;
        logic          hs_last_q;
        logic [RW-1:0] off_run_q;
        logic          armed_q;

        // Length of the current run of equal synchronised samples, per command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ls_run_q  <= '0;
                ls_last_q <= 1'b1;
                hs_run_q  <= '0;
                hs_last_q <= 1'b1;
            end else begin
                ls_last_q <= ls_sync[i];
                hs_last_q <= hs_sync[i];
                if (ls_sync[i] != ls_last_q) ls_run_q <= RW'(1);
                else if (ls_run_q != SAT_V)  ls_run_q <= ls_run_q + 1'b1;
                if (hs_sync[i] != hs_last_q) hs_run_q <= RW'(1);
                else if (hs_run_q != SAT_V)  hs_run_q <= hs_run_q + 1'b1;
            end
        end

        // Length of the current high-side off period, armed once the output has been on.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_run_q <= '0;
                armed_q   <= 1'b0;
            end else begin
                armed_q <= armed_q | !hs_out_n[i];
                if (!hs_out_n[i])              off_run_q <= '0;
                else if (off_run_q != SAT_V)   off_run_q <= off_run_q + 1'b1;
            end
        end

        AST_LS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
            (ls_out_n[i] != $past(ls_out_n[i])) |-> (ls_run_q >= LS_MIN && ls_last_q == ls_out_n[i])); // R2

        AST_HS_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hs_out_n[i]) |-> (hs_run_q >= ON_MIN && !hs_last_q)); // R4

        AST_HS_OFF_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_out_n[i]) |-> (hs_run_q >= SH_MIN && hs_last_q)); // R5

        AST_HS_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(hs_out_n[i]) && armed_q) |-> (off_run_q >= OFF_MINV)); // R7
    end

endmodule

bind gate_input_filter gate_input_filter_chk #(
    .N_LEGS           (N_LEGS),
    .LS_FILT_CYC      (LS_FILT_CYC),
    .HS_ON_CYC        (HS_ON_CYC),
    .HS_OFF_SHORT_CYC (HS_OFF_SHORT_CYC),
    .HS_OFF_LONG_CYC  (HS_OFF_LONG_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ls_sync  (ls_sync),
    .hs_sync  (hs_sync),
    .ls_out_n (ls_out_n),
    .hs_out_n (hs_out_n)
);

// File: tb/gate_input_filter_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected output transitions
// (cycle, channel, level), and a monitor pops and compares each change it sees.
// Channel numbering: 0..N-1 are low-side, N..2N-1 are high-side.
module gate_input_filter_tb;

    localparam int NL   = 3;
    localparam int LSF  = 54;
    localparam int HSON = 54;
    localparam int SH   = 44;
    localparam int LG   = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] ls_cmd_n = '1;
    logic [NL-1:0] hs_cmd_n = '1;
    logic [NL-1:0] ls_out_n;
    logic [NL-1:0] hs_out_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;
    string cur_req = "R1";

    int    q_at[$];
    int    q_ch[$];
    logic  q_val[$];
    string q_req[$];

    gate_input_filter #(
        .N_LEGS(NL), .LS_FILT_CYC(LSF), .HS_ON_CYC(HSON),
        .HS_OFF_SHORT_CYC(SH), .HS_OFF_LONG_CYC(LG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ls_cmd_n(ls_cmd_n), .hs_cmd_n(hs_cmd_n),
        .ls_out_n(ls_out_n), .hs_out_n(hs_out_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic push(input int at, input int ch, input logic val, input string req);
        q_at.push_back(at); q_ch.push_back(ch); q_val.push_back(val); q_req.push_back(req);
    endtask

    task automatic set_cmd(input int ch, input logic val);
        if (ch < NL) ls_cmd_n[ch] = val;
        else         hs_cmd_n[ch-NL] = val;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Direct level check of one output channel.
    task automatic chk_out(input int ch, input logic exp, input string req);
        logic act;
        act = (ch < NL) ? ls_out_n[ch] : hs_out_n[ch-NL];
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d level %b expected %b", req, ch, act, exp);
        end
    endtask

    // Any expected transition still queued never happened.
    task automatic drain(input string req);
        while (q_at.size() > 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %s missing edge ch%0d at cycle %0d actual none expected %b",
                     req, q_ch[0], q_at[0], q_val[0]);
            void'(q_at.pop_front()); void'(q_ch.pop_front());
            void'(q_val.pop_front()); void'(q_req.pop_front());
        end
    endtask

    // Low-side pulse to on (0) for w cycles, starting from off.
    task automatic ls_pulse(input int ch, input int w, input string req);
        int k;
        cur_req = req;
        k = cyc;
        set_cmd(ch, 1'b0);
        if (w >= LSF) begin
            push(k + LSF + 2, ch, 1'b0, req);
            push(k + w + LSF + 2, ch, 1'b1, req);
        end
        idle(w);
        set_cmd(ch, 1'b1);
        idle(LSF + 10);
        chk_out(ch, 1'b1, req);
        drain(req);
    endtask

    // Held level change on any channel with a given expected delay.
    task automatic level(input int ch, input logic val, input int dly, input string req);
        int k;
        cur_req = req;
        k = cyc;
        set_cmd(ch, val);
        push(k + dly, ch, val, req);
        idle(dly + 8);
        drain(req);
    endtask

    // High-side off-pulse of w cycles on a channel that is on.
    task automatic hs_offpulse(input int ch, input int w, input string req);
        int k;
        int back;
        cur_req = req;
        k = cyc;
        set_cmd(ch, 1'b1);
        if (w >= SH) begin
            back = (w > LG) ? w : LG;
            push(k + SH + 2, ch, 1'b1, req);
            push(k + back + HSON + 2, ch, 1'b0, req);
        end
        idle(w);
        set_cmd(ch, 1'b0);
        idle(LG + HSON + 12);
        chk_out(ch, 1'b0, req);
        drain(req);
    endtask

    // Monitor: every output change is compared against the queue head.
    logic [2*NL-1:0] prev;
    always @(negedge clk) begin
        logic [2*NL-1:0] now;
        now = {hs_out_n, ls_out_n};
        if (mon_en) begin
            for (int ch = 0; ch < 2*NL; ch++) begin
                if (now[ch] !== prev[ch]) begin
                    n_cmp++;
                    if (q_at.size() == 0) begin
                        n_bad++;
                        $display("FAIL %s unexpected edge ch%0d at cycle %0d actual %b expected none",
                                 cur_req, ch, cyc, now[ch]);
                    end else begin
                        if (q_ch[0] != ch || q_at[0] != cyc || q_val[0] !== now[ch]) begin
                            n_bad++;
                            $display("FAIL %s edge ch%0d cycle %0d val %b expected ch%0d cycle %0d val %b",
                                     q_req[0], ch, cyc, now[ch], q_ch[0], q_at[0], q_val[0]);
                        end
                        void'(q_at.pop_front()); void'(q_ch.pop_front());
                        void'(q_val.pop_front()); void'(q_req.pop_front());
                    end
                end
            end
        end
        prev = now;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        // R1: reset state, during and right after reset
        idle(5);
        for (int ch = 0; ch < 2*NL; ch++) chk_out(ch, 1'b1, "R1");
        rst_n = 1'b1;
        idle(3);
        for (int ch = 0; ch < 2*NL; ch++) chk_out(ch, 1'b1, "R1");
        mon_en = 1'b1;

        // R2: low-side on and off edges, long pulse and exact boundary
        ls_pulse(0, 120, "R2");
        ls_pulse(1, LSF, "R2");
        // R3: one cycle short of the filter time is dropped
        ls_pulse(2, LSF - 1, "R3");
        ls_pulse(0, 3, "R3");
        // R3: short off glitch while the low side is on
        level(1, 1'b0, LSF + 2, "R2");
        cur_req = "R3";
        set_cmd(1, 1'b1); idle(LSF - 1); set_cmd(1, 1'b0);
        idle(LSF + 10);
        chk_out(1, 1'b0, "R3");
        level(1, 1'b1, LSF + 2, "R2");

        // R4: short on-request to high side ignored, then a held one passes
        cur_req = "R4";
        set_cmd(NL, 1'b0); idle(HSON - 1); set_cmd(NL, 1'b1);
        idle(HSON + 10);
        chk_out(NL, 1'b1, "R4");
        level(NL, 1'b0, HSON + 2, "R4");

        // R5: short off-pulses ignored
        hs_offpulse(NL, SH - 1, "R5");
        hs_offpulse(NL, 4, "R5");

        // R7: intermediate off-pulses stretched
        hs_offpulse(NL, SH, "R7");
        hs_offpulse(NL, 60, "R7");
        hs_offpulse(NL, LG - 1, "R7");

        // R6: long off-pulses pass
        hs_offpulse(NL, LG, "R6");
        hs_offpulse(NL, LG + 30, "R6");

        // R8: other channels move while high side 0 stays on
        level(NL + 1, 1'b0, HSON + 2, "R8");
        hs_offpulse(NL + 1, 60, "R8");
        ls_pulse(2, 90, "R8");
        chk_out(NL, 1'b0, "R8");
        chk_out(0, 1'b1, "R8");

        // R6: held turn-off on high side 2 after turning on
        level(NL + 2, 1'b0, HSON + 2, "R4");
        level(NL + 2, 1'b1, SH + 2, "R6");
        chk_out(NL, 1'b0, "R8");

        // Bring all high sides back off
        level(NL, 1'b1, SH + 2, "R6");
        cur_req = "R6";
        k = cyc;
        set_cmd(NL + 1, 1'b1);
        push(k + SH + 2, NL + 1, 1'b1, "R6");
        idle(LG + 10);
        drain("R6");
        for (int ch = 0; ch < 2*NL; ch++) chk_out(ch, 1'b1, "R8");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule